// File: doc/BRIEF.md
# Dual-Protocol Host Register Interface

This block lets an 8-bit host processor read and write a small register file inside the chip. Two strap inputs set how the host talks to it. The first selects the handshake style. With the strap at 1, one strobe pin is an active-low data strobe and the other is a read/write direction line. With the strap at 0, the two pins are separate active-low read and write strobes. The second strap selects the addressing style. With it at 1, the 8-bit data bus also carries the address. With it at 0, a separate 7-bit address bus supplies the address.

In both addressing styles, the address is captured when the latch-enable input falls. Every host-side control pin passes through a two-flop synchroniser into the system clock. Edge detection runs on the synchronised copies, so each register write takes effect in a single clock cycle.

The core logic behind the registers is reduced to event pulse inputs and control register outputs. Event pulses set sticky interrupt flags. The host clears a flag by writing 1 to its bit. Flags that are set and enabled produce an active-low open-drain interrupt request.

Top module: `hostbus_slave`

## Requirements
- R1: With `bus_dir_mode`=1, `data_oe` is asserted and `data_out` carries the addressed register while `sel_n`=0, `strb_a_n`=0 (data strobe) and `strb_b_n`=1 (direction = read).
- R2: With `bus_dir_mode`=1, a rising edge of `strb_a_n` while `strb_b_n`=0 writes `data_in` into the addressed register. A rising edge of `strb_a_n` while `strb_b_n`=1 writes nothing.
- R3: With `bus_dir_mode`=0, `strb_a_n`=0 alone drives read data. A rising edge of `strb_b_n` writes. A read strobe cycle never writes.
- R4: While `sel_n`=1, strobe activity neither drives the bus nor writes any register.
- R5: With `bus_shared`=1, the address comes from `data_in[6:0]`. With `bus_shared`=0, it comes from `addr_sep`. In both cases it is taken at the falling edge of `addr_latch`.
- R6: Changes on the address source after the falling edge of `addr_latch` do not alter the address used by the following data phase.
- R7: Register map: 0x00 holds the interrupt flags, 0x01 holds the interrupt enables (bit = 1 unmasks), and 0x02 to 0x05 are control registers. Control register k appears on `ctrl_q[8k+7:8k]`.
- R8: A 1 on `evt_set[i]` for one cycle sets flag i, and the flag stays set. Writing 1 to bit i of address 0x00 clears flag i. Writing 0 leaves the flag unchanged.
- R9: `int_req_n` is 0 exactly when some flag is set and its enable bit is 1. The enables reset to 0, so every flag starts masked.
- R10: Reads from addresses 0x06 to 0x7F return 0. Writes to those addresses change no register.
- R11: `rst_n`=0 clears all registers at once, without waiting for a clock edge.
- R12: `data_oe` is 0 outside a qualified read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_dir_mode | input | 1 | 1: data strobe with direction line; 0: separate read and write strobes |
| bus_shared | input | 1 | 1: address carried on the data bus; 0: separate address bus |
| sel_n | input | 1 | Active-low chip select |
| strb_a_n | input | 1 | Data strobe (mode 1) or read strobe (mode 0) |
| strb_b_n | input | 1 | Direction line, 1 = read (mode 1), or write strobe (mode 0) |
| addr_latch | input | 1 | Address latch enable; address captured on its falling edge |
| addr_sep | input | 7 | Separate address bus |
| data_in | input | 8 | Data bus as driven by the host |
| data_out | output | 8 | Read data driven toward the bus |
| data_oe | output | 1 | Bus output enable |
| evt_set | input | 8 | Core event pulses that set interrupt flags |
| ctrl_q | output | 32 | Control register contents, four bytes |
| int_req_n | output | 1 | Open-drain interrupt request; 0 = pull low |

## Verification
The bench builds the block with its default parameters: 7 address bits, 8 data bits and four control registers. This small configuration allows every strap combination to be driven and the whole 128-entry address space to be swept. Write/read-back, interrupt masking and flag clearing are repeated under each of the four handshake and addressing combinations. The bench also checks that writes to every unimplemented address are discarded, and that strobes issued while deselected, or with the direction line set to read, leave all registers untouched.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic {
        HS_SPLIT = 1'b0,
        HS_DIR   = 1'b1
    } hs_mode_e;

    typedef struct packed {
        logic sel_n;
        logic a_n;
        logic b_n;
        logic latch;
    } bus_pins_t;

    typedef struct packed {
        logic rd_act;
        logic wr_stb;
        logic adr_stb;
    } bus_evt_t;

    localparam logic [3:0] PINS_IDLE = 4'b1110;

    localparam int STAT_ADDR = 0;
    localparam int EN_ADDR   = 1;
    localparam int CTRL_BASE = 2;

    // Turns synchronised pin levels of this and the previous cycle into bus events
    function automatic bus_evt_t decode_evt(hs_mode_e mode, bus_pins_t cur, bus_pins_t prv);
        bus_evt_t e;
        logic held_sel;
        held_sel  = ~cur.sel_n & ~prv.sel_n;
        e.adr_stb = prv.latch & ~cur.latch;
        if (mode == HS_DIR) begin
            e.rd_act = ~cur.sel_n & ~cur.a_n & cur.b_n;
            e.wr_stb = held_sel & cur.a_n & ~prv.a_n & ~cur.b_n & ~prv.b_n;
        end else begin
            e.rd_act = ~cur.sel_n & ~cur.a_n;
            e.wr_stb = held_sel & cur.b_n & ~prv.b_n;
        end
        return e;
    endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/hb_decode.sv
module hb_decode
    import hb_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_mode,
    input  logic              shared,
    input  bus_pins_t         pins_raw,
    input  logic [ADDR_W-1:0] addr_bus,
    input  logic [ADDR_W-1:0] addr_mux,
    output bus_evt_t          evt,
    output logic [ADDR_W-1:0] addr_q
);
    logic [3:0] pins_s_v;
    bus_pins_t  pins_s, pins_p;

    hb_sync #(.W(4), .RST_VAL(PINS_IDLE)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pins_raw),
        .q    (pins_s_v)
    );

    assign pins_s = bus_pins_t'(pins_s_v);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_p <= bus_pins_t'(PINS_IDLE);
        else        pins_p <= pins_s;
    end

    assign evt = decode_evt(hs_mode_e'(dir_mode), pins_s, pins_p);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           addr_q <= '0;
        else if (evt.adr_stb) addr_q <= shared ? addr_mux : addr_bus;
    end
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile
    import hb_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int N_CTRL = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_stb,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [DATA_W-1:0]        evt_set,
    output logic [DATA_W-1:0]        rdata,
    output logic [N_CTRL*DATA_W-1:0] ctrl_q,
    output logic                     int_req_n
);
    logic [DATA_W-1:0] flag_q, en_q;
    logic [DATA_W-1:0] ctrl_r [N_CTRL];
    logic              hit_stat, hit_en;
    logic [DATA_W-1:0] clr_mask;

    assign hit_stat = wr_stb && (addr == ADDR_W'(STAT_ADDR));
    assign hit_en   = wr_stb && (addr == ADDR_W'(EN_ADDR));
    assign clr_mask = hit_stat ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_mask) | evt_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_q <= '0;
        else if (hit_en) en_q <= wdata;
    end

    for (genvar k = 0; k < N_CTRL; k++) begin : g_ctrl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_r[k] <= '0;
            else if (wr_stb && (addr == ADDR_W'(CTRL_BASE + k)))
                ctrl_r[k] <= wdata;
        end
        assign ctrl_q[k*DATA_W +: DATA_W] = ctrl_r[k];
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(STAT_ADDR)) rdata = flag_q;
        if (addr == ADDR_W'(EN_ADDR))   rdata = en_q;
        for (int k = 0; k < N_CTRL; k++) begin
            if (addr == ADDR_W'(CTRL_BASE + k)) rdata = ctrl_r[k];
        end
    end

    assign int_req_n = ~|(flag_q & en_q);
endmodule

// File: rtl/hostbus_slave.sv
module hostbus_slave
    import hb_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int N_CTRL = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_dir_mode,
    input  logic                     bus_shared,
    input  logic                     sel_n,
    input  logic                     strb_a_n,
    input  logic                     strb_b_n,
    input  logic                     addr_latch,
    input  logic [ADDR_W-1:0]        addr_sep,
    input  logic [DATA_W-1:0]        data_in,
    output logic [DATA_W-1:0]        data_out,
    output logic                     data_oe,
    input  logic [DATA_W-1:0]        evt_set,
    output logic [N_CTRL*DATA_W-1:0] ctrl_q,
    output logic                     int_req_n
);
    bus_pins_t         pins;
    bus_evt_t          evt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] rdata;
    logic              wr_stb;

    assign pins = '{sel_n: sel_n, a_n: strb_a_n, b_n: strb_b_n, latch: addr_latch};

    hb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_mode(bus_dir_mode),
        .shared  (bus_shared),
        .pins_raw(pins),
        .addr_bus(addr_sep),
        .addr_mux(data_in[ADDR_W-1:0]),
        .evt     (evt),
        .addr_q  (addr_q)
    );

    assign wr_stb = evt.wr_stb;

    hb_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CTRL(N_CTRL)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .addr     (addr_q),
        .wdata    (data_in),
        .evt_set  (evt_set),
        .rdata    (rdata),
        .ctrl_q   (ctrl_q),
        .int_req_n(int_req_n)
    );

    assign data_oe  = evt.rd_act;
    assign data_out = evt.rd_act ? rdata : '0;
endmodule

// File: rtl/hb_chk.sv
module hb_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              data_oe,
    input logic              int_req_n,
    input logic [DATA_W-1:0] evt_set,
    input logic [DATA_W-1:0] flags,
    input logic              wr_stb
);
    // R4 R12
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && $past(sel_n) && $past(sel_n, 2)) |-> !data_oe);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ((flags & $past(flags)) == $past(flags)));

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_set) |=> ((flags & $past(evt_set)) == $past(evt_set)));

    // R9
    irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_req_n |-> (|flags));
endmodule

bind hostbus_slave hb_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .data_oe  (data_oe),
    .int_req_n(int_req_n),
    .evt_set  (evt_set),
    .flags    (u_rf.flag_q),
    .wr_stb   (wr_stb)
);

// File: tb/sim_hostbus_slave.sv
module sim_hostbus_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_dir_mode = 1'b0, bus_shared = 1'b0;
    logic        sel_n = 1'b1, strb_a_n = 1'b1, strb_b_n = 1'b1, addr_latch = 1'b0;
    logic [6:0]  addr_sep = '0;
    logic [7:0]  data_in = '0, evt_set = '0;
    logic [7:0]  data_out;
    logic        data_oe, int_req_n;
    logic [31:0] ctrl_q;

    int total = 0, bad = 0;
    logic [7:0] ctrl_m [4];
    logic [7:0] en_m = '0, flag_m = '0;

    always #2.5 clk = ~clk;

    hostbus_slave u0 (
        .clk(clk), .rst_n(rst_n), .bus_dir_mode(bus_dir_mode), .bus_shared(bus_shared),
        .sel_n(sel_n), .strb_a_n(strb_a_n), .strb_b_n(strb_b_n), .addr_latch(addr_latch),
        .addr_sep(addr_sep), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .evt_set(evt_set), .ctrl_q(ctrl_q), .int_req_n(int_req_n)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R5 R6: address phase, then the address source is scrambled
    task automatic addr_phase(logic [6:0] a);
        if (bus_shared) begin
            data_in  = {1'b0, a};
            addr_sep = ~a;
        end else begin
            addr_sep = a;
            data_in  = {1'b1, ~a};
        end
        addr_latch = 1'b1; tick(3);
        addr_latch = 1'b0; tick(4);
        addr_sep = ~a;
        data_in  = {1'b0, ~a};
    endtask

    task automatic bus_write(logic [6:0] a, logic [7:0] d);
        addr_phase(a);
        data_in = d;
        sel_n = 1'b0;
        if (bus_dir_mode) begin
            strb_b_n = 1'b0; tick(2);
            strb_a_n = 1'b0; tick(3);
            strb_a_n = 1'b1; tick(4);
            strb_b_n = 1'b1;
        end else begin
            tick(2);
            strb_b_n = 1'b0; tick(3);
            strb_b_n = 1'b1; tick(4);
        end
        sel_n = 1'b1; tick(3);
    endtask

    task automatic bus_read(logic [6:0] a, output logic [7:0] d, output logic oe);
        addr_phase(a);
        data_in = '0;
        sel_n = 1'b0; strb_b_n = 1'b1; strb_a_n = 1'b0; tick(4);
        d = data_out; oe = data_oe;
        strb_a_n = 1'b1; tick(3);
        sel_n = 1'b1; tick(3);
    endtask

    task automatic pulse(logic [7:0] v);
        evt_set = v; tick(1); evt_set = '0; tick(1);
        flag_m |= v;
    endtask

    task automatic check_ctrl(string req);
        for (int k = 0; k < 4; k++) chk(req, ctrl_q[k*8 +: 8], ctrl_m[k]);
    endtask

    initial begin
        logic [7:0] rd;
        logic       oe;
        for (int k = 0; k < 4; k++) ctrl_m[k] = '0;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R11 R9 R12: reset state
        check_ctrl("R11 reset ctrl");
        chk("R9 reset irq", int_req_n, 1'b1);
        chk("R12 idle oe", data_oe, 1'b0);

        for (int m = 0; m < 4; m++) begin
            bus_dir_mode = m[0];
            bus_shared   = m[1];
            // R7 R1 R2 R3 R5 R6: write then read every control register
            for (int k = 0; k < 4; k++) begin
                ctrl_m[k] = 8'(m * 37 + k * 53 + 7);
                bus_write(7'(2 + k), ctrl_m[k]);
            end
            check_ctrl("R7 ctrl port after write");
            for (int k = 0; k < 4; k++) begin
                bus_read(7'(2 + k), rd, oe);
                chk(m[0] ? "R1 read drive oe" : "R3 read drive oe", oe, 1'b1);
                chk("R5 R6 readback", rd, ctrl_m[k]);
                chk("R12 oe after read", data_oe, 1'b0);
            end
            // read strobes ended without writing
            check_ctrl(m[0] ? "R2 read cycle no write" : "R3 read strobe no write");

            // R8 R9: flags, masking, clear
            pulse(8'(8'h05 << m));
            chk("R9 masked irq", int_req_n, ((flag_m & en_m) == 0));
            bus_read(7'(0), rd, oe);
            chk("R8 flags sticky", rd, flag_m);
            en_m = 8'(8'h04 << m);
            bus_write(7'(1), en_m);
            chk("R9 unmasked irq", int_req_n, ((flag_m & en_m) == 0));
            bus_read(7'(1), rd, oe);
            chk("R7 enable readback", rd, en_m);
            bus_write(7'(0), 8'(8'h04 << m));
            flag_m &= ~(8'(8'h04 << m));
            chk("R9 irq released", int_req_n, ((flag_m & en_m) == 0));
            bus_read(7'(0), rd, oe);
            chk("R8 clear one", rd, flag_m);
            bus_write(7'(0), 8'h00);
            bus_read(7'(0), rd, oe);
            chk("R8 write zero keeps", rd, flag_m);
            bus_write(7'(0), 8'hFF);
            flag_m = '0;
            bus_read(7'(0), rd, oe);
            chk("R8 clear all", rd, 8'h00);

            // R4: deselected strobes
            addr_phase(7'(2));
            data_in = 8'hC3;
            strb_a_n = 1'b0; strb_b_n = 1'b0; tick(4);
            chk("R4 deselected oe", data_oe, 1'b0);
            strb_a_n = 1'b1; tick(2); strb_b_n = 1'b1; tick(4);
            check_ctrl("R4 deselected write");
            strb_b_n = 1'b1; strb_a_n = 1'b0; tick(4);
            chk("R4 deselected read oe", data_oe, 1'b0);
            strb_a_n = 1'b1; tick(3);
        end

        // R10: sweep unimplemented addresses
        for (int a = 6; a < 128; a++) begin
            bus_write(7'(a), 8'hFF);
            bus_read(7'(a), rd, oe);
            chk("R10 unimplemented read", rd, 8'h00);
        end
        check_ctrl("R10 writes ignored");
        bus_read(7'(1), rd, oe);
        chk("R10 enable untouched", rd, en_m);

        // R11: asynchronous reset between clock edges
        pulse(8'h80);
        bus_write(7'(1), 8'h80);
        en_m = 8'h80;
        chk("R9 irq before reset", int_req_n, 1'b0);
        #1 rst_n = 1'b0;
        #1;
        chk("R11 async ctrl clear", ctrl_q, 32'h0);
        chk("R11 async irq release", int_req_n, 1'b1);
        tick(2);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) ctrl_m[k] = '0;
        flag_m = '0; en_m = '0;
        tick(2);
        bus_read(7'(0), rd, oe);
        chk("R11 flags cleared", rd, 8'h00);
        bus_read(7'(1), rd, oe);
        chk("R11 enables cleared", rd, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule